// File: doc/BRIEF.md
# Disk Data-Port Write Posting and Read Prefetch Controller

This block sits between the host-side I/O decoder and the drive cycle sequencer of a two-channel disk controller. Writes to a channel's data port can be posted: the host is released in the same cycle and the word is written to the drive later from a small buffer. Reads from a data port can start a prefetch. The first read from a channel is a demand read. It waits for the drive. The block then fetches the next word at once, so that the next read of the same size on the same channel is answered from a holding register without waiting.

The block also enforces ordering. While the write buffer holds data, only further posted writes to the same channel's data port are accepted. Every other access waits until the buffer has been written out. Only one drive cycle is outstanding at a time, and a prefetch cycle that is in flight always completes before another access is launched. Posting and prefetching are enabled per channel by static configuration inputs.

Top module: `pio_dport_ctrl`

## Requirements
- R1: The primary data port is address 0x1F0 (channel 0) and the secondary data port is 0x170 (channel 1). Every other address is a non-data access whose channel is taken from address bit 7 (1 selects channel 0, 0 selects channel 1).
- R2: A data-port write is accepted with `h_ack` in the same cycle as `h_req` when all of the following hold: posting is enabled for its channel, the buffer is not full, the buffer is empty or holds data for the same channel, and no read cycle is outstanding.
- R3: The write buffer holds two entries. A posted write that arrives while the buffer is full is held without acknowledge until an entry drains.
- R4: Buffered writes reach the drive in arrival order, as data-port writes to the buffer's channel.
- R5: While the buffer is not empty, every access other than a same-channel posted write is held, and its drive cycle is issued only after the last buffered word has been written.
- R6: A prefetch-enabled data-port read with no matching prefetched word is a demand read. It is acknowledged when its drive cycle completes, and a read of the same channel and size is issued on the next cycle.
- R7: A read that matches the prefetched word in channel and size (`h_sz32`: 1 = 32 bits, 0 = 16 bits) is acknowledged in the cycle of the request with that word, and the next prefetch starts in the following cycle.
- R8: Any access other than a matching read, including a read of the other size, discards the prefetched word. The next data-port read is then a demand read.
- R9: `d_req` and the cycle's address and direction stay stable until `d_ack`. Only one drive cycle is ever in flight.
- R10: With posting or prefetching disabled for a channel, its data-port accesses are plain drive cycles acknowledged on `d_ack`, and no extra read is issued.
- R11: After reset, `d_req` and `h_ack` are low and both the buffer and the prefetch register are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_post_en | input | 2 | Write posting enable, one bit per channel |
| cfg_pref_en | input | 2 | Read prefetch enable, one bit per channel |
| h_req | input | 1 | Host access request, held until `h_ack` |
| h_we | input | 1 | Host access is a write |
| h_sz32 | input | 1 | Access size: 1 = 32 bits, 0 = 16 bits |
| h_addr | input | 10 | Host I/O address |
| h_wdata | input | 32 | Host write data |
| h_ack | output | 1 | Host access complete |
| h_rdata | output | 32 | Host read data, valid with `h_ack` |
| d_req | output | 1 | Drive cycle request, held until `d_ack` |
| d_we | output | 1 | Drive cycle is a write |
| d_ch | output | 1 | Drive cycle channel |
| d_sz32 | output | 1 | Drive cycle size |
| d_addr | output | 10 | Drive cycle I/O address |
| d_wdata | output | 32 | Drive cycle write data |
| d_ack | input | 1 | Drive cycle complete (one-cycle pulse) |
| d_rdata | input | 32 | Drive read data, valid with `d_ack` |

## Verification
Four properties are checked on every cycle: the drive request stays stable until its acknowledge, the buffer is never pushed while full, no read cycle runs while write data is still buffered, and every prefetch hit is followed by a new read request. Acknowledges are also checked to come only in answer to a request. The bench scenarios cover the rest. They show which word a read returns as the stream advances and after a discard, and they show which acknowledges come without waiting. They also show the order of drive cycles behind a drained buffer and what happens when posting or prefetching is switched off.

// File: rtl/pio_dport_pkg.sv
package pio_dport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRAIN = 2'd1,
    ST_HOST  = 2'd2,
    ST_PREF  = 2'd3
  } drv_state_t;
endpackage

// File: rtl/pio_dport_decode.sv
module pio_dport_decode #(
  parameter int AW = 10,
  parameter logic [AW-1:0] PRI_PORT = 10'h1F0,
  parameter logic [AW-1:0] SEC_PORT = 10'h170
) (
  input  logic [AW-1:0] addr,
  output logic          is_data,
  output logic          ch
);
  always_comb begin
    is_data = (addr == PRI_PORT) || (addr == SEC_PORT);
    // bit 7 set selects the primary channel
    ch      = ~addr[7];
  end
endmodule

// File: rtl/pio_dport_wbuf.sv
module pio_dport_wbuf #(
  parameter int DEPTH = 2,
  parameter int W     = 33,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head_data,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_n, rp_q, rp_n;
  logic [CW-1:0] cnt_q, cnt_n;

  function automatic logic [PW-1:0] inc_ptr(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + PW'(1);
  endfunction

  always_comb begin
    wp_n  = push ? inc_ptr(wp_q) : wp_q;
    rp_n  = pop  ? inc_ptr(rp_q) : rp_q;
    cnt_n = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && (wp_q == PW'(i))) mem_q[i] <= push_data;
    end
  end

  assign head_data = mem_q[rp_q];
  assign empty     = (cnt_q == '0);
  assign full      = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pio_dport_fsm.sv
module pio_dport_fsm
  import pio_dport_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter logic [AW-1:0] PRI_PORT = 10'h1F0,
  parameter logic [AW-1:0] SEC_PORT = 10'h170
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    post_en,
  input  logic [1:0]    pref_en,
  input  logic          h_req,
  input  logic          h_we,
  input  logic          h_sz32,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  input  logic          is_data,
  input  logic          ch,
  output logic          h_ack,
  output logic [DW-1:0] h_rdata,
  input  logic          wb_empty,
  input  logic          wb_full,
  input  logic [DW:0]   wb_head,
  output logic          wb_push,
  output logic          wb_pop,
  output logic          pf_hit,
  output logic          d_req,
  output logic          d_we,
  output logic          d_ch,
  output logic          d_sz32,
  output logic [AW-1:0] d_addr,
  output logic [DW-1:0] d_wdata,
  input  logic          d_ack,
  input  logic [DW-1:0] d_rdata
);
  drv_state_t st_q, st_n;
  logic          wb_ch_q, wb_ch_n;
  logic          pf_vld_q, pf_vld_n, pf_ch_q, pf_ch_n, pf_sz_q, pf_sz_n;
  logic [DW-1:0] pf_data_q, pf_data_n;
  logic          dem_q, dem_n;
  logic          dwe_n, dch_n, dsz_n;
  logic [AW-1:0] dad_n;
  logic [DW-1:0] dwd_n;
  logic          post_path, post_ok, launch_drain, launch_host, host_done;

  function automatic logic [AW-1:0] port_of(input logic c);
    return c ? SEC_PORT : PRI_PORT;
  endfunction

  always_comb begin
    post_path    = h_req && h_we && is_data && post_en[ch];
    post_ok      = post_path && !wb_full && (wb_empty || (wb_ch_q == ch)) &&
                   ((st_q == ST_IDLE) || (st_q == ST_DRAIN));
    pf_hit       = h_req && !h_we && is_data && pref_en[ch] && pf_vld_q &&
                   (pf_ch_q == ch) && (pf_sz_q == h_sz32) &&
                   (st_q == ST_IDLE) && wb_empty;
    launch_drain = (st_q == ST_IDLE) && !wb_empty;
    launch_host  = (st_q == ST_IDLE) && wb_empty && h_req && !post_path && !pf_hit;
    host_done    = (st_q == ST_HOST) && d_ack;
    h_ack        = post_ok || pf_hit || host_done;
    h_rdata      = pf_hit ? pf_data_q : d_rdata;
    wb_push      = post_ok;
    wb_pop       = (st_q == ST_DRAIN) && d_ack;
  end

  always_comb begin
    st_n      = st_q;
    wb_ch_n   = post_ok ? ch : wb_ch_q;
    pf_vld_n  = pf_vld_q;
    pf_ch_n   = pf_ch_q;
    pf_sz_n   = pf_sz_q;
    pf_data_n = pf_data_q;
    dem_n     = dem_q;
    dwe_n     = d_we;
    dch_n     = d_ch;
    dsz_n     = d_sz32;
    dad_n     = d_addr;
    dwd_n     = d_wdata;
    if (post_ok || pf_hit || launch_host) pf_vld_n = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (launch_drain) begin
          st_n  = ST_DRAIN;
          dwe_n = 1'b1;
          dch_n = wb_ch_q;
          dsz_n = wb_head[DW];
          dad_n = port_of(wb_ch_q);
          dwd_n = wb_head[DW-1:0];
        end else if (pf_hit) begin
          st_n  = ST_PREF;
          dwe_n = 1'b0;
          dch_n = pf_ch_q;
          dsz_n = pf_sz_q;
          dad_n = port_of(pf_ch_q);
        end else if (launch_host) begin
          st_n  = ST_HOST;
          dem_n = !h_we && is_data && pref_en[ch];
          dwe_n = h_we;
          dch_n = ch;
          dsz_n = h_sz32;
          dad_n = h_addr;
          dwd_n = h_wdata;
        end
      end
      ST_DRAIN: if (d_ack) st_n = ST_IDLE;
      ST_HOST:  if (d_ack) st_n = dem_q ? ST_PREF : ST_IDLE;
      ST_PREF: begin
        if (d_ack) begin
          st_n      = ST_IDLE;
          pf_vld_n  = 1'b1;
          pf_ch_n   = d_ch;
          pf_sz_n   = d_sz32;
          pf_data_n = d_rdata;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      wb_ch_q   <= 1'b0;
      pf_vld_q  <= 1'b0;
      pf_ch_q   <= 1'b0;
      pf_sz_q   <= 1'b0;
      dem_q     <= 1'b0;
      d_req     <= 1'b0;
      d_we      <= 1'b0;
      d_ch      <= 1'b0;
      d_sz32    <= 1'b0;
      d_addr    <= '0;
      d_wdata   <= '0;
      pf_data_q <= '0;
    end else begin
      st_q      <= st_n;
      wb_ch_q   <= wb_ch_n;
      pf_vld_q  <= pf_vld_n;
      pf_ch_q   <= pf_ch_n;
      pf_sz_q   <= pf_sz_n;
      dem_q     <= dem_n;
      d_req     <= (st_n != ST_IDLE);
      d_we      <= dwe_n;
      d_ch      <= dch_n;
      d_sz32    <= dsz_n;
      d_addr    <= dad_n;
      d_wdata   <= dwd_n;
      pf_data_q <= pf_data_n;
    end
  end
endmodule

// File: rtl/pio_dport_ctrl.sv
module pio_dport_ctrl #(
  parameter int AW       = 10,
  parameter int DW       = 32,
  parameter int WB_DEPTH = 2,
  parameter logic [AW-1:0] PRI_PORT = 10'h1F0,
  parameter logic [AW-1:0] SEC_PORT = 10'h170
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    cfg_post_en,
  input  logic [1:0]    cfg_pref_en,
  input  logic          h_req,
  input  logic          h_we,
  input  logic          h_sz32,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic          h_ack,
  output logic [DW-1:0] h_rdata,
  output logic          d_req,
  output logic          d_we,
  output logic          d_ch,
  output logic          d_sz32,
  output logic [AW-1:0] d_addr,
  output logic [DW-1:0] d_wdata,
  input  logic          d_ack,
  input  logic [DW-1:0] d_rdata
);
  localparam int EW = DW + 1;

  logic          rst_s1_q, rst_s2_q;
  logic          is_data, ch;
  logic          wb_push, wb_pop, wb_empty, wb_full, pf_hit;
  logic [EW-1:0] wb_head;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  pio_dport_decode #(.AW(AW), .PRI_PORT(PRI_PORT), .SEC_PORT(SEC_PORT)) i_dec (
    .addr(h_addr), .is_data(is_data), .ch(ch)
  );

  pio_dport_wbuf #(.DEPTH(WB_DEPTH), .W(EW)) i_wbuf (
    .clk(clk), .rst_n(rst_s2_q), .push(wb_push), .push_data({h_sz32, h_wdata}),
    .pop(wb_pop), .head_data(wb_head), .empty(wb_empty), .full(wb_full)
  );

  pio_dport_fsm #(.AW(AW), .DW(DW), .PRI_PORT(PRI_PORT), .SEC_PORT(SEC_PORT)) i_fsm (
    .clk(clk), .rst_n(rst_s2_q), .post_en(cfg_post_en), .pref_en(cfg_pref_en),
    .h_req(h_req), .h_we(h_we), .h_sz32(h_sz32), .h_addr(h_addr), .h_wdata(h_wdata),
    .is_data(is_data), .ch(ch), .h_ack(h_ack), .h_rdata(h_rdata),
    .wb_empty(wb_empty), .wb_full(wb_full), .wb_head(wb_head),
    .wb_push(wb_push), .wb_pop(wb_pop), .pf_hit(pf_hit),
    .d_req(d_req), .d_we(d_we), .d_ch(d_ch), .d_sz32(d_sz32), .d_addr(d_addr),
    .d_wdata(d_wdata), .d_ack(d_ack), .d_rdata(d_rdata)
  );
endmodule

// File: rtl/pio_dport_ctrl_chk.sv
module pio_dport_ctrl_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h_req,
  input logic          h_ack,
  input logic          d_req,
  input logic          d_we,
  input logic          d_ack,
  input logic [AW-1:0] d_addr,
  input logic          wb_full,
  input logic          wb_push,
  input logic          wb_empty,
  input logic          pf_hit
);
  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_ack) |=> (d_req && $stable(d_addr) && $stable(d_we)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wb_full |-> !wb_push);

  a_r5_read_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (d_req && !d_we) |-> wb_empty);

  a_r7_hit_refetch: assert property (@(posedge clk) disable iff (!rst_n)
    pf_hit |=> (d_req && !d_we));

  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    h_ack |-> h_req);
endmodule

bind pio_dport_ctrl pio_dport_ctrl_chk #(.AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .h_req(h_req), .h_ack(h_ack), .d_req(d_req),
  .d_we(d_we), .d_ack(d_ack), .d_addr(d_addr), .wb_full(wb_full),
  .wb_push(wb_push), .wb_empty(wb_empty), .pf_hit(pf_hit)
);

// File: tb/test_pio_dport_ctrl.sv
module test_pio_dport_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_post_en = 2'b11, cfg_pref_en = 2'b11;
  logic        h_req = 1'b0, h_we = 1'b0, h_sz32 = 1'b0;
  logic [9:0]  h_addr = '0;
  logic [31:0] h_wdata = '0;
  logic        h_ack;
  logic [31:0] h_rdata;
  logic        d_req, d_we, d_ch, d_sz32;
  logic [9:0]  d_addr;
  logic [31:0] d_wdata;
  logic        d_ack = 1'b0;
  logic [31:0] d_rdata = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pio_dport_ctrl i_pio_dport_ctrl (.*);

  // drive-side model and cycle log
  int       rd_idx [2];
  logic     lg_we   [64];
  logic [9:0]  lg_addr [64];
  logic [31:0] lg_data [64];
  int       lg_n = 0;

  function automatic logic [31:0] word(input int c, input int i);
    return 32'hC000_0000 | (32'(c) << 16) | 32'(i);
  endfunction

  initial begin : drive_model
    int cnt;
    cnt = 0; rd_idx[0] = 0; rd_idx[1] = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin d_ack = 0; cnt = 0; end
      else if (d_ack) begin d_ack = 0; cnt = 0; end
      else if (d_req) begin
        cnt++;
        if (cnt == 3) begin
          d_ack = 1; cnt = 0;
          if (d_we) d_rdata = '0;
          else if (d_addr == 10'h1F0 || d_addr == 10'h170) begin
            d_rdata = word(int'(d_ch), rd_idx[d_ch]); rd_idx[d_ch]++;
          end else d_rdata = 32'h5A00_0000 | 32'(d_addr);
          if (lg_n < 64) begin
            lg_we[lg_n] = d_we; lg_addr[lg_n] = d_addr;
            lg_data[lg_n] = d_we ? d_wdata : d_rdata; lg_n++;
          end
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one host access; returns wait cycles before ack and read data
  task automatic access(input logic we, input logic [9:0] a, input logic sz,
                        input logic [31:0] wd, input int gap,
                        output int waits, output logic [31:0] rd);
    for (int g = 0; g < gap; g++) @(negedge clk);
    h_req = 1; h_we = we; h_addr = a; h_sz32 = sz; h_wdata = wd;
    waits = 0;
    forever begin
      #1;
      if (h_ack) break;
      @(negedge clk); waits++;
    end
    rd = h_rdata;
    @(negedge clk);
    h_req = 0;
  endtask

  typedef struct packed {
    logic        we;
    logic [9:0]  addr;
    logic        sz;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        fast;
    logic [3:0]  gap;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{1'b0, 10'h1F0, 1'b1, 32'h0, 32'hC000_0000, 1'b0, 4'd2}, // R6 demand
    '{1'b0, 10'h1F0, 1'b1, 32'h0, 32'hC000_0001, 1'b1, 4'd6}, // R7 hit
    '{1'b0, 10'h1F0, 1'b1, 32'h0, 32'hC000_0002, 1'b1, 4'd6}, // R7 hit
    '{1'b0, 10'h1F0, 1'b0, 32'h0, 32'hC000_0004, 1'b0, 4'd6}, // R8 size change
    '{1'b0, 10'h1F0, 1'b0, 32'h0, 32'hC000_0005, 1'b1, 4'd6}, // R7 16-bit hit
    '{1'b0, 10'h170, 1'b1, 32'h0, 32'hC001_0000, 1'b0, 4'd6}, // R1 R8 other channel
    '{1'b1, 10'h170, 1'b1, 32'hA1, 32'h0, 1'b1, 4'd6},        // R2 post
    '{1'b1, 10'h170, 1'b1, 32'hA2, 32'h0, 1'b1, 4'd0},        // R2 post
    '{1'b1, 10'h170, 1'b1, 32'hA3, 32'h0, 1'b0, 4'd0},        // R3 full
    '{1'b0, 10'h1F7, 1'b0, 32'h0, 32'h5A00_01F7, 1'b0, 4'd0}, // R5 R1 non-data
    '{1'b0, 10'h1F0, 1'b1, 32'h0, 32'hC000_0007, 1'b0, 4'd6}  // R8 new demand
  };
  localparam string VTAG [NV] = '{"R6","R7","R7","R8","R7","R8","R2","R2","R3","R5","R8"};

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int w, n0;
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 d_req", 32'(d_req), 32'd0);
    check("R11 h_ack", 32'(h_ack), 32'd0);

    for (int i = 0; i < NV; i++) begin
      access(VT[i].we, VT[i].addr, VT[i].sz, VT[i].wd, int'(VT[i].gap), w, rd);
      if (!VT[i].we) check($sformatf("%s vec%0d data", VTAG[i], i), rd, VT[i].exp);
      check($sformatf("%s vec%0d fast", VTAG[i], i), 32'(w == 0), 32'(VT[i].fast));
      if (i == 9) begin
        // R4 R5: three posted writes drained in order before the non-data read
        check("R4 order0", {lg_we[lg_n-4], 22'(lg_addr[lg_n-4])}, {1'b1, 22'h170});
        check("R4 data0", lg_data[lg_n-4], 32'hA1);
        check("R4 data1", lg_data[lg_n-3], 32'hA2);
        check("R4 data2", lg_data[lg_n-2], 32'hA3);
        check("R5 last is read", 32'(lg_we[lg_n-1]), 32'd0);
      end
    end

    // R10: prefetch off on channel 0 (word 8 sits prefetched): read is plain, no refetch
    repeat (6) @(negedge clk);
    cfg_pref_en = 2'b10;
    n0 = lg_n;
    access(1'b0, 10'h1F0, 1'b1, 32'h0, 1, w, rd);
    check("R10 plain read data", rd, word(0, 9));
    check("R10 plain read waits", 32'(w > 0), 32'd1);
    repeat (8) @(negedge clk);
    check("R10 no extra read", 32'(lg_n - n0), 32'd1);

    // R10: posting off on channel 0: write waits for drive
    cfg_post_en = 2'b10;
    access(1'b1, 10'h1F0, 1'b1, 32'hB0, 1, w, rd);
    check("R10 unposted waits", 32'(w > 0), 32'd1);
    check("R10 unposted data", lg_data[lg_n-1], 32'hB0);

    // R9: one cycle in flight; demand read then prefetch keeps request order
    cfg_pref_en = 2'b11;
    access(1'b0, 10'h170, 1'b0, 32'h0, 1, w, rd);
    check("R6 ch1 demand", rd, word(1, 2));
    repeat (8) @(negedge clk);
    check("R9 prefetch issued after demand", lg_data[lg_n-1], word(1, 3));
    check("R9 idle after prefetch", 32'(d_req), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule